// File: doc/BRIEF.md
# Memory Patrol Scrubber with Refresh-Upgrade Reporting

The scrubber sweeps the whole memory one word at a time, on a fixed cycle interval. Each stored word holds 64 data bits and 8 check bits of a single-error-correct, double-error-detect Hamming code. For every word it reads, the block decodes the codeword and takes one of three actions:

- **Clean word:** it moves on.
- **Correctable word:** it writes the repaired codeword back to the same address. It also emits a one-cycle upgrade event that carries the row index of that word. A refresh-rate table uses this event to move the row back to the normal refresh rate, so weak cells cannot build up in one word until a second error makes it unrecoverable.
- **Uncorrectable word:** it flags the word and leaves it unchanged.

Two saturating counters keep the number of corrected words and of uncorrectable words. A pulse marks the end of each sweep.

The memory side is a request channel with valid/ready. A request is held, with all of its fields stable, until it is accepted. The read data comes back later on a response strobe that has no back-pressure. Only one request is in flight at any time. The control pins and status pins are plain levels and pulses.

Top module: `patrol_scrubber`

## Requirements
- R1: While reset is asserted, and in the cycle after it, the block makes no memory request, raises no event pulse, and both counters read zero.
- R2: After `scrub_en` rises, the first read request becomes visible in the (INTERVAL+1)th cycle. A sweep reads every address from 0 to 2^ADDR_W-1 exactly once, in ascending order.
- R3: A request that is valid and not accepted keeps `mem_req_valid`, its address, its write flag and its write data unchanged until it is accepted. A new read is issued only after the response to the previous read has arrived.
- R4: A word whose codeword is consistent is never written back, and it changes neither counter.
- R5: The codeword layout is as follows:
  - bits 63:0 hold the data, with data bit j at the j-th position (counting from 0) among positions 1..71 that are not powers of two;
  - bit 64+i is the Hamming check over every position that has bit i set;
  - bit 71 makes the parity of all 72 bits even.

  A single flipped bit at any of the 72 positions is repaired, and the repaired codeword is written to the same address before the next read.
- R6: Each corrected word produces exactly one one-cycle `upg_valid` pulse, with `upg_row` equal to the word address shifted right by ROW_SHIFT. The pulses come in sweep order.
- R7: A word with two flipped bits is not written. It raises a one-cycle `unc_valid` pulse with `unc_addr` set to its address, and the uncorrectable counter increments.
- R8: Both counters increment by one per event and stop at 2^CNT_W-1 without wrapping.
- R9: `pass_done` is a one-cycle pulse, raised once after the last word of each sweep has been handled.
- R10: Interval expiries that occur during a sweep merge into a single pending start. The next sweep begins only after the current sweep has finished. Dropping `scrub_en` cancels a pending start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scrub_en | input | 1 | Runs the interval timer; low clears the timer and any pending start |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_write | output | 1 | 1 = write, 0 = read |
| mem_req_addr | output | ADDR_W | Word address |
| mem_req_wdata | output | 72 | Repaired codeword for a write |
| mem_rsp_valid | input | 1 | Read data strobe |
| mem_rsp_data | input | 72 | Codeword that was read |
| upg_valid | output | 1 | Refresh-upgrade event |
| upg_row | output | ADDR_W-ROW_SHIFT | Row to upgrade |
| unc_valid | output | 1 | Uncorrectable-word event |
| unc_addr | output | ADDR_W | Address of the uncorrectable word |
| pass_done | output | 1 | End-of-sweep pulse |
| corr_count | output | CNT_W | Saturating count of corrected words |
| unc_count | output | CNT_W | Saturating count of uncorrectable words |

## Verification
The bench flips bits in the data field, in the Hamming check bits and in the overall parity bit 71. A decoder that places a syndrome wrongly would write back a word that is still corrupt, or report a single-bit error as uncorrectable.

Double-bit errors are left in memory across several sweeps. The uncorrectable counter is driven past its limit, which catches a counter that wraps and a design that tries to repair such a word. Clean sweeps check that nothing is written back.

Random back-pressure on the request channel catches requests that change while they wait. A short interval makes the timer expire during a sweep, which exposes overlapping or lost sweeps.

// File: rtl/scrub_pkg.sv
package scrub_pkg;

  localparam int DATA_W = 64;
  localparam int HAM_W  = 7;
  localparam int CW_W   = 72;

  typedef enum logic [1:0] {
    WORD_CLEAN   = 2'd0,
    WORD_FIXABLE = 2'd1,
    WORD_FATAL   = 2'd2
  } word_kind_e;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_READ  = 3'd1,
    ST_WAIT  = 3'd2,
    ST_EXAM  = 3'd3,
    ST_WRITE = 3'd4,
    ST_STEP  = 3'd5
  } scrub_state_e;

  // Position (1..71) held by data bit j: the j-th non-power-of-two slot.
  function automatic int data_slot(input int j);
    int k;
    int res;
    k   = 0;
    res = 0;
    for (int p = 1; p < CW_W; p++) begin
      if ((p & (p - 1)) != 0) begin
        if (k == j) res = p;
        k++;
      end
    end
    return res;
  endfunction

  // Hamming check bits over the data field.
  function automatic logic [HAM_W-1:0] ham_bits(input logic [DATA_W-1:0] d);
    logic [HAM_W-1:0] h;
    int               p;
    h = '0;
    for (int j = 0; j < DATA_W; j++) begin
      p = data_slot(j);
      for (int i = 0; i < HAM_W; i++) begin
        if (p[i]) h[i] = h[i] ^ d[j];
      end
    end
    return h;
  endfunction

endpackage

// File: rtl/secded_word_check.sv
module secded_word_check
  import scrub_pkg::*;
(
  input  logic [CW_W-1:0] cw_i,
  output logic [CW_W-1:0] cw_fix_o,
  output word_kind_e      kind_o
);

  logic [HAM_W-1:0] syn;
  logic             par;
  logic             fixable;
  logic [CW_W-1:0]  flip;

  assign syn = cw_i[DATA_W +: HAM_W] ^ ham_bits(cw_i[DATA_W-1:0]);
  assign par = ^cw_i;

  always_comb begin
    if (!par) begin
      kind_o = (syn == '0) ? WORD_CLEAN : WORD_FATAL;
    end else if (syn == '0) begin
      kind_o = WORD_FIXABLE;
    end else if (int'(syn) > CW_W - 1) begin
      kind_o = WORD_FATAL;
    end else begin
      kind_o = WORD_FIXABLE;
    end
  end

  assign fixable = (kind_o == WORD_FIXABLE);

  for (genvar j = 0; j < DATA_W; j++) begin : g_data_flip
    localparam int SLOT = data_slot(j);
    assign flip[j] = fixable && (syn == HAM_W'(SLOT));
  end

  for (genvar i = 0; i < HAM_W; i++) begin : g_check_flip
    assign flip[DATA_W+i] = fixable && (syn == HAM_W'(1 << i));
  end

  assign flip[CW_W-1] = fixable && (syn == '0);

  assign cw_fix_o = cw_i ^ flip;

endmodule

// File: rtl/scrub_pace_timer.sv
module scrub_pace_timer #(
  parameter longint unsigned INTERVAL = 64'd1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic take_i,
  output logic start_o
);

  localparam int TW = (INTERVAL > 64'd1) ? $clog2(INTERVAL) : 1;
  localparam logic [TW-1:0] LIMIT = TW'(INTERVAL - 64'd1);

  logic [TW-1:0] tick_cnt;
  logic          pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick_cnt <= '0;
      pend     <= 1'b0;
    end else if (!en_i) begin
      tick_cnt <= '0;
      pend     <= 1'b0;
    end else begin
      if (take_i) pend <= 1'b0;
      if (tick_cnt == LIMIT) begin
        tick_cnt <= '0;
        pend     <= 1'b1;
      end else begin
        tick_cnt <= tick_cnt + 1'b1;
      end
    end
  end

  assign start_o = pend && en_i;

endmodule

// File: rtl/sat_count.sv
module sat_count #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         bump_i,
  output logic [W-1:0] value_o
);

  localparam logic [W-1:0] TOP = '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      value_o <= '0;
    end else if (bump_i && value_o != TOP) begin
      value_o <= value_o + 1'b1;
    end
  end

endmodule

// File: rtl/patrol_scrubber.sv
module patrol_scrubber
  import scrub_pkg::*;
#(
  parameter int              ADDR_W    = 20,
  parameter int              ROW_SHIFT = 7,
  parameter longint unsigned INTERVAL  = 64'd225_000_000_000,
  parameter int              CNT_W     = 16,
  localparam int             ROW_W     = ADDR_W - ROW_SHIFT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scrub_en,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_write,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [CW_W-1:0]   mem_req_wdata,
  input  logic              mem_rsp_valid,
  input  logic [CW_W-1:0]   mem_rsp_data,
  output logic              upg_valid,
  output logic [ROW_W-1:0]  upg_row,
  output logic              unc_valid,
  output logic [ADDR_W-1:0] unc_addr,
  output logic              pass_done,
  output logic [CNT_W-1:0]  corr_count,
  output logic [CNT_W-1:0]  unc_count
);

  localparam logic [ADDR_W-1:0] LAST_ADDR = '1;

  scrub_state_e      state;
  logic [ADDR_W-1:0] addr_q;
  logic [CW_W-1:0]   rd_q;
  logic [CW_W-1:0]   fixed_cw;
  word_kind_e        kind;
  logic              start_req;
  logic              take;
  logic              bump_corr;
  logic              bump_unc;

  scrub_pace_timer #(.INTERVAL(INTERVAL)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .en_i    (scrub_en),
    .take_i  (take),
    .start_o (start_req)
  );

  secded_word_check u_check (
    .cw_i     (rd_q),
    .cw_fix_o (fixed_cw),
    .kind_o   (kind)
  );

  assign take      = (state == ST_IDLE) && start_req;
  assign bump_corr = (state == ST_EXAM) && (kind == WORD_FIXABLE);
  assign bump_unc  = (state == ST_EXAM) && (kind == WORD_FATAL);

  sat_count #(.W(CNT_W)) u_corr_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .bump_i  (bump_corr),
    .value_o (corr_count)
  );

  sat_count #(.W(CNT_W)) u_unc_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .bump_i  (bump_unc),
    .value_o (unc_count)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      addr_q    <= '0;
      rd_q      <= '0;
      upg_valid <= 1'b0;
      upg_row   <= '0;
      unc_valid <= 1'b0;
      unc_addr  <= '0;
      pass_done <= 1'b0;
    end else begin
      upg_valid <= 1'b0;
      unc_valid <= 1'b0;
      pass_done <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (start_req) begin
            addr_q <= '0;
            state  <= ST_READ;
          end
        end
        ST_READ: begin
          if (mem_req_ready) state <= ST_WAIT;
        end
        ST_WAIT: begin
          if (mem_rsp_valid) begin
            rd_q  <= mem_rsp_data;
            state <= ST_EXAM;
          end
        end
        ST_EXAM: begin
          unique case (kind)
            WORD_FIXABLE: begin
              upg_valid <= 1'b1;
              upg_row   <= addr_q[ADDR_W-1:ROW_SHIFT];
              state     <= ST_WRITE;
            end
            WORD_FATAL: begin
              unc_valid <= 1'b1;
              unc_addr  <= addr_q;
              state     <= ST_STEP;
            end
            default: state <= ST_STEP;
          endcase
        end
        ST_WRITE: begin
          if (mem_req_ready) state <= ST_STEP;
        end
        ST_STEP: begin
          if (addr_q == LAST_ADDR) begin
            pass_done <= 1'b1;
            state     <= ST_IDLE;
          end else begin
            addr_q <= addr_q + 1'b1;
            state  <= ST_READ;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign mem_req_valid = (state == ST_READ) || (state == ST_WRITE);
  assign mem_req_write = (state == ST_WRITE);
  assign mem_req_addr  = addr_q;
  assign mem_req_wdata = fixed_cw;

endmodule

// File: rtl/patrol_scrubber_checker.sv
module patrol_scrubber_checker #(
  parameter int ADDR_W    = 20,
  parameter int ROW_SHIFT = 7,
  parameter int CNT_W     = 16
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      mem_req_valid,
  input logic                      mem_req_ready,
  input logic                      mem_req_write,
  input logic [ADDR_W-1:0]         mem_req_addr,
  input logic [71:0]               mem_req_wdata,
  input logic                      upg_valid,
  input logic [ADDR_W-ROW_SHIFT-1:0] upg_row,
  input logic                      unc_valid,
  input logic                      pass_done,
  input logic [CNT_W-1:0]          corr_count,
  input logic [CNT_W-1:0]          unc_count
);

  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_n |=> (!mem_req_valid && !upg_valid && !unc_valid && !pass_done &&
                corr_count == '0 && unc_count == '0));

  assert_req_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=>
      (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_write) &&
       $stable(mem_req_wdata)));

  assert_upg_then_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    upg_valid |-> (mem_req_valid && mem_req_write));

  assert_upg_one_cycle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    upg_valid |=> !upg_valid);

  assert_corr_moves_with_upg_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(corr_count) |-> upg_valid);

  assert_unc_moves_with_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(unc_count) |-> unc_valid);

  assert_corr_no_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (corr_count >= $past(corr_count)));

  assert_unc_no_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (unc_count >= $past(unc_count)));

  assert_done_one_cycle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pass_done |=> !pass_done);

endmodule

bind patrol_scrubber patrol_scrubber_checker #(
  .ADDR_W    (ADDR_W),
  .ROW_SHIFT (ROW_SHIFT),
  .CNT_W     (CNT_W)
) u_checker (
  .clk           (clk),
  .rst_n         (rst_n),
  .mem_req_valid (mem_req_valid),
  .mem_req_ready (mem_req_ready),
  .mem_req_write (mem_req_write),
  .mem_req_addr  (mem_req_addr),
  .mem_req_wdata (mem_req_wdata),
  .upg_valid     (upg_valid),
  .upg_row       (upg_row),
  .unc_valid     (unc_valid),
  .pass_done     (pass_done),
  .corr_count    (corr_count),
  .unc_count     (unc_count)
);

// File: tb/tb_patrol_scrubber.sv
`timescale 1ns/1ps
module tb_patrol_scrubber;

  localparam int              AW = 5;
  localparam int              RS = 2;
  localparam int              CW = 4;
  localparam longint unsigned IV = 40;
  localparam int              NW = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          scrub_en = 1'b0;
  logic          mem_req_valid, mem_req_write, rdy = 1'b0;
  logic [AW-1:0] mem_req_addr;
  logic [71:0]   mem_req_wdata;
  logic          rsp_v = 1'b0;
  logic [71:0]   rsp_d = '0;
  logic          upg_valid, unc_valid, pass_done;
  logic [AW-RS-1:0] upg_row;
  logic [AW-1:0] unc_addr;
  logic [CW-1:0] corr_count, unc_count;

  always #2 clk = ~clk;

  patrol_scrubber #(.ADDR_W(AW), .ROW_SHIFT(RS), .INTERVAL(IV), .CNT_W(CW)) dut (
    .clk(clk), .rst_n(rst_n), .scrub_en(scrub_en),
    .mem_req_valid(mem_req_valid), .mem_req_ready(rdy), .mem_req_write(mem_req_write),
    .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
    .mem_rsp_valid(rsp_v), .mem_rsp_data(rsp_d),
    .upg_valid(upg_valid), .upg_row(upg_row), .unc_valid(unc_valid), .unc_addr(unc_addr),
    .pass_done(pass_done), .corr_count(corr_count), .unc_count(unc_count)
  );

  // memory model and monitors
  logic [71:0] mem [NW];
  logic        inj_en = 1'b0;
  logic [AW-1:0] inj_addr = '0;
  logic [71:0] inj_val = '0;
  logic [AW-1:0] exp_rd = '0, last_rd = '0;
  int rd_order_err = 0, wr_addr_err = 0;
  int reads_in_pass = 0, writes_in_pass = 0, snap_reads = 0, snap_writes = 0;
  int upg_n = 0, unc_n = 0;
  int upg_log [256];
  int unc_log [256];
  int r3_viol = 0;
  logic p_valid = 1'b0, p_ready = 1'b0, p_write = 1'b0;
  logic [AW-1:0] p_addr = '0;
  logic [71:0] p_wdata = '0;

  always @(negedge clk) rdy <= ($urandom % 4) != 0;

  always @(posedge clk) begin
    rsp_v   <= 1'b0;
    p_valid <= mem_req_valid;
    p_ready <= rdy;
    p_addr  <= mem_req_addr;
    p_write <= mem_req_write;
    p_wdata <= mem_req_wdata;
    if (inj_en) mem[inj_addr] <= inj_val;
    if (pass_done) begin
      snap_reads     <= reads_in_pass;
      snap_writes    <= writes_in_pass;
      reads_in_pass  <= 0;
      writes_in_pass <= 0;
    end
    if (mem_req_valid && rdy) begin
      if (mem_req_write) begin
        mem[mem_req_addr] <= mem_req_wdata;
        if (mem_req_addr != last_rd) wr_addr_err <= wr_addr_err + 1;
        writes_in_pass <= writes_in_pass + 1;
      end else begin
        rsp_v   <= 1'b1;
        rsp_d   <= mem[mem_req_addr];
        if (mem_req_addr != exp_rd) rd_order_err <= rd_order_err + 1;
        exp_rd  <= mem_req_addr + 1'b1;
        last_rd <= mem_req_addr;
        reads_in_pass <= reads_in_pass + 1;
      end
    end
    if (upg_valid) begin
      upg_log[upg_n] <= int'(upg_row);
      upg_n <= upg_n + 1;
    end
    if (unc_valid) begin
      unc_log[unc_n] <= int'(unc_addr);
      unc_n <= unc_n + 1;
    end
  end

  // R3 back-pressure hold monitor
  always @(negedge clk) begin
    if (rst_n && p_valid && !p_ready) begin
      if (!mem_req_valid || mem_req_addr != p_addr || mem_req_write != p_write ||
          mem_req_wdata != p_wdata)
        r3_viol <= r3_viol + 1;
    end
  end

  int checks = 0, fails = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  // reference encoder built from the layout stated in R5
  function automatic logic [71:0] enc(input logic [63:0] d);
    logic [71:0] slot;
    logic [6:0]  c;
    logic [71:0] cw;
    int j;
    slot = '0;
    j = 0;
    for (int p = 1; p < 72; p++) begin
      if ((p & (p - 1)) != 0) begin
        slot[p] = d[j];
        j++;
      end
    end
    for (int i = 0; i < 7; i++) begin
      c[i] = 1'b0;
      for (int p = 1; p < 72; p++)
        if (((p >> i) & 1) == 1 && (p & (p - 1)) != 0) c[i] ^= slot[p];
    end
    cw = {1'b0, c, d};
    cw[71] = ^cw[70:0];
    return cw;
  endfunction

  logic [71:0] orig [NW];
  logic [71:0] expect_mem [NW];
  bit single_now [NW];
  bit fatal [NW];
  int first_req_cyc = 0;

  task automatic poke(input int a, input logic [71:0] v);
    inj_addr = AW'(a);
    inj_val  = v;
    inj_en   = 1'b1;
    @(negedge clk);
    inj_en   = 1'b0;
  endtask

  task automatic put_single(input int a, input int b);
    poke(a, orig[a] ^ (72'd1 << b));
    expect_mem[a] = orig[a];
    single_now[a] = 1'b1;
  endtask

  task automatic put_double(input int a, input int b0, input int b1);
    logic [71:0] m;
    m = (72'd1 << b0) | (72'd1 << b1);
    poke(a, orig[a] ^ m);
    expect_mem[a] = orig[a] ^ m;
    fatal[a] = 1'b1;
  endtask

  task automatic run_passes(input int npass, input int exp_corr, input int exp_unc,
                            input bit time_first);
    int ub, nb, seen, cyc, nsingle, nfatal, bad, k, lastw;
    ub = upg_n; nb = unc_n; seen = 0; cyc = 0; first_req_cyc = 0;
    scrub_en = 1'b1;
    while (seen < npass) begin
      @(negedge clk);
      cyc++;
      if (first_req_cyc == 0 && mem_req_valid) first_req_cyc = cyc;
      if (pass_done) seen++;
    end
    scrub_en = 1'b0;
    @(negedge clk);
    if (time_first)
      chk(first_req_cyc == int'(IV) + 1, "R2", "first read cycle after enable",
          first_req_cyc, int'(IV) + 1);
    chk(seen == npass, "R9", "sweeps completed", seen, npass);
    bad = 0;
    for (int a = 0; a < NW; a++) if (mem[a] !== expect_mem[a]) bad++;
    chk(bad == 0, "R5", "words differing from expected after sweep (R7 doubles kept)", bad, 0);
    nsingle = 0; nfatal = 0;
    for (int a = 0; a < NW; a++) begin
      if (single_now[a]) nsingle++;
      if (fatal[a]) nfatal++;
    end
    chk(upg_n - ub == nsingle, "R6", "upgrade pulses", upg_n - ub, nsingle);
    k = ub;
    bad = 0;
    for (int a = 0; a < NW; a++) if (single_now[a]) begin
      if (k < upg_n && upg_log[k] != (a >> RS)) bad++;
      k++;
    end
    chk(bad == 0, "R6", "upgrade rows out of order or wrong", bad, 0);
    chk(unc_n - nb == npass * nfatal, "R7", "uncorrectable pulses", unc_n - nb, npass * nfatal);
    k = nb;
    bad = 0;
    for (int r = 0; r < npass; r++)
      for (int a = 0; a < NW; a++) if (fatal[a]) begin
        if (k < unc_n && unc_log[k] != a) bad++;
        k++;
      end
    chk(bad == 0, "R7", "uncorrectable addresses", bad, 0);
    chk(int'(corr_count) == exp_corr, "R8", "corrected counter", corr_count, exp_corr);
    chk(int'(unc_count) == exp_unc, "R8", "uncorrectable counter", unc_count, exp_unc);
    chk(snap_reads == NW, "R2", "reads in last sweep", snap_reads, NW);
    lastw = (npass == 1) ? nsingle : 0;
    chk(snap_writes == lastw, "R4", "write-backs in last sweep", snap_writes, lastw);
    chk(rd_order_err == 0, "R10", "read order / overlapping sweeps", rd_order_err, 0);
    chk(wr_addr_err == 0, "R5", "write-back address differs from read", wr_addr_err, 0);
    for (int a = 0; a < NW; a++) single_now[a] = 1'b0;
  endtask

  initial begin
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk);
    chk(!mem_req_valid && !upg_valid && !unc_valid && !pass_done, "R1",
        "outputs quiet in reset", mem_req_valid, 0);
    chk(corr_count == '0 && unc_count == '0, "R1", "counters in reset",
        corr_count + unc_count, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!mem_req_valid, "R1", "no request after reset while disabled", mem_req_valid, 0);
    for (int a = 0; a < NW; a++) begin
      orig[a] = enc({$urandom, $urandom});
      expect_mem[a] = orig[a];
      single_now[a] = 1'b0;
      fatal[a] = 1'b0;
      poke(a, orig[a]);
    end
    // directed: data, Hamming check and overall parity positions
    put_single(0, 0);
    put_single(3, 63);
    put_single(7, 64);
    put_single(12, 70);
    put_single(20, 33);
    put_single(31, 71);
    put_double(5, 0, 71);
    put_double(18, 64, 65);
    put_double(26, 10, 40);
    run_passes(1, 6, 3, 1'b1);
    // random single errors, R8 saturation of corrected count
    for (int n = 0; n < 10; n++) begin
      int a;
      a = int'($urandom % NW);
      while (fatal[a] || single_now[a]) a = int'($urandom % NW);
      put_single(a, int'($urandom % 72));
    end
    run_passes(1, 15, 6, 1'b0);
    // R4 clean sweeps, R10 back-to-back with the timer expiring during a sweep
    run_passes(2, 15, 12, 1'b0);
    // R8 saturation of uncorrectable count
    run_passes(2, 15, 15, 1'b0);
    chk(r3_viol == 0, "R3", "request changed while stalled", r3_viol, 0);
    // R10 dropping enable cancels: no request appears while disabled
    repeat (3 * int'(IV)) @(negedge clk);
    chk(!mem_req_valid && reads_in_pass == 0, "R10", "activity while disabled",
        reads_in_pass, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule